// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block sits beside the sequencer of a simple in-order CPU core and runs once at every instruction boundary. The core pulses `eval_i` when an instruction has retired. The arbiter then picks the one asynchronous or trap condition to service on that boundary, using a fixed priority: a task-switch trap, then other debug traps, then a maskable interrupt, then a DMA hold request. If none of these applies, the core continues. The chosen action comes back one cycle later as a code with a `done_o` strobe. The strobe tells the core it may begin the next fetch.

The arbiter keeps a small amount of state. It holds the pending debug-trap word, which is fed by `trap_set_i` and by single-step scheduling. It holds a sticky debug-status word, into which serviced traps are merged. It holds a two-bit inhibit mask, whose bits are set by pulses from instructions that load the stack segment or enable interrupts. The mask suppresses interrupt or debug servicing for exactly one boundary. It also holds a pending-event flag.

When the core is halted, the arbiter waits without issuing anything. It wakes on an enabled interrupt request or on a reset event, and it discards any stale traps and inhibits when it wakes.

Top module: `boundary_event_arbiter`

## Requirements
- R1: An evaluation with `halt_i`=1 issues nothing until `intr_i`&`if_i` or `wake_rst_i` is seen. On that cycle it issues action code 1 (wake) one cycle later and clears the trap word and the inhibit mask.
- R2: If bit 15 (task-switch) of the trap word is set, the boundary issues action code 2 (debug exception), even when debug events are inhibited.
- R3: Any other nonzero trap word issues code 2 only when the debug-inhibit bit is clear. Otherwise the traps stay in `trap_sched_o` for the next boundary.
- R4: When no debug exception is taken, code 3 (interrupt acknowledge) is issued only if the interrupt-inhibit bit is clear, `intr_i`=1 and `if_i`=1. `ext_o` is high exactly with code 3.
- R5: Code 4 (hold acknowledge) is issued when `hold_req_i`=1 and neither a debug exception nor an interrupt is taken.
- R6: With `tf_i`=1 on a boundary that takes no debug exception, bit 14 (single-step) is set in `trap_sched_o`, so a debug exception follows on the next boundary.
- R7: `rf_clr_o` pulses together with `done_o` when `rf_i`=1 and no debug exception is taken.
- R8: Inhibit-set pulses take effect on the next boundary only. Every completed evaluation clears the inhibit mask.
- R9: `pending_o` is set by any interrupt request, hold request, trap bit or `tf_i`. After an evaluation it stays set only if one of these still remains.
- R10: Each non-halted evaluation yields exactly one `done_o` pulse, one cycle after `eval_i`. Code 0 means continue.
- R11: A debug exception ORs the pending trap word into the sticky `dbg_status_o` and empties the trap word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| eval_i | input | 1 | Instruction boundary reached |
| halt_i | input | 1 | Core is in halt state at this boundary |
| wake_rst_i | input | 1 | Reset event that ends halt |
| trap_set_i | input | TRAP_W | Trap bits posted by the retiring instruction |
| tf_i | input | 1 | Single-step flag |
| rf_i | input | 1 | Resume flag |
| if_i | input | 1 | Interrupt-enable flag |
| intr_i | input | 1 | Maskable interrupt request |
| hold_req_i | input | 1 | DMA hold request |
| inh_int_set_i | input | 1 | Inhibit interrupts for the next boundary |
| inh_dbg_set_i | input | 1 | Inhibit debug events for the next boundary |
| act_o | output | 3 | Action code: 0 continue, 1 wake, 2 debug exception, 3 interrupt ack, 4 hold ack |
| done_o | output | 1 | One-cycle strobe: action valid, fetch may proceed |
| ext_o | output | 1 | Serviced event is external |
| rf_clr_o | output | 1 | Clear the resume flag |
| dbg_status_o | output | TRAP_W | Accumulated debug status |
| trap_sched_o | output | TRAP_W | Traps scheduled for the next boundary |
| pending_o | output | 1 | Some event source remains |

## Verification
The hardest situations to reach are two carried-over cases. The first is a trap that was deferred by the debug inhibit and must fire on a later boundary. The second is a single-step trap scheduled on one boundary, then held back by an inhibit on the next, and only then serviced. The vector table chains boundaries so that the trap word carries state from one row into the next, and the expected schedule is written after every row. A halted wait is entered with stale traps and an interrupt inhibit already armed. The first boundary after wake then shows an interrupt taken, which proves both were discarded.

// File: rtl/boundary_event_arbiter.sv
module boundary_event_arbiter #(
  parameter int TRAP_W   = 32,
  parameter int TASK_BIT = 15,
  parameter int STEP_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic              halt_i,
  input  logic              wake_rst_i,
  input  logic [TRAP_W-1:0] trap_set_i,
  input  logic              tf_i,
  input  logic              rf_i,
  input  logic              if_i,
  input  logic              intr_i,
  input  logic              hold_req_i,
  input  logic              inh_int_set_i,
  input  logic              inh_dbg_set_i,
  output logic [2:0]        act_o,
  output logic              done_o,
  output logic              ext_o,
  output logic              rf_clr_o,
  output logic [TRAP_W-1:0] dbg_status_o,
  output logic [TRAP_W-1:0] trap_sched_o,
  output logic              pending_o
);
  localparam logic [2:0] ACT_CONT = 3'd0;
  localparam logic [2:0] ACT_WAKE = 3'd1;
  localparam logic [2:0] ACT_DBG  = 3'd2;
  localparam logic [2:0] ACT_INT  = 3'd3;
  localparam logic [2:0] ACT_HOLD = 3'd4;
  localparam logic [TRAP_W-1:0] STEP_MASK = TRAP_W'(1) << STEP_BIT;

  logic [TRAP_W-1:0] trap_q, status_q, trap_nx;
  logic [1:0]        inh_q;
  logic              waiting_q, done_q, ext_q, rf_clr_q, pend_q;
  logic [2:0]        act_q, act_n;

  wire wake_ok = (intr_i && if_i) || wake_rst_i;
  wire in_halt = waiting_q || (eval_i && halt_i);
  wire normal  = eval_i && !halt_i && !waiting_q;
  wire dbg_hit = trap_q[TASK_BIT] || ((|trap_q) && !inh_q[1]);
  wire int_hit = !inh_q[0] && intr_i && if_i;
  wire [1:0] inh_set = {inh_dbg_set_i, inh_int_set_i};

  always_comb begin
    if (dbg_hit)         act_n = ACT_DBG;
    else if (int_hit)    act_n = ACT_INT;
    else if (hold_req_i) act_n = ACT_HOLD;
    else                 act_n = ACT_CONT;
    if (dbg_hit) trap_nx = trap_set_i;
    else         trap_nx = trap_q | trap_set_i | (tf_i ? STEP_MASK : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q    <= '0;
      status_q  <= '0;
      inh_q     <= '0;
      waiting_q <= 1'b0;
      done_q    <= 1'b0;
      ext_q     <= 1'b0;
      rf_clr_q  <= 1'b0;
      pend_q    <= 1'b0;
      act_q     <= ACT_CONT;
    end else begin
      done_q   <= 1'b0;
      ext_q    <= 1'b0;
      rf_clr_q <= 1'b0;
      inh_q    <= inh_q | inh_set;
      trap_q   <= trap_q | trap_set_i;
      pend_q   <= pend_q | intr_i | hold_req_i | tf_i | (|trap_set_i);
      if (in_halt) begin
        if (wake_ok) begin
          waiting_q <= 1'b0;
          done_q    <= 1'b0 | 1'b1;
          act_q     <= ACT_WAKE;
          trap_q    <= trap_set_i;
          inh_q     <= inh_set;
          pend_q    <= intr_i | hold_req_i | tf_i | (|trap_set_i);
        end else begin
          waiting_q <= 1'b1;
        end
      end else if (normal) begin
        done_q   <= 1'b1;
        act_q    <= act_n;
        ext_q    <= (act_n == ACT_INT);
        rf_clr_q <= rf_i && !dbg_hit;
        inh_q    <= inh_set;
        trap_q   <= trap_nx;
        if (dbg_hit) status_q <= status_q | trap_q;
        pend_q   <= intr_i | hold_req_i | tf_i | (|trap_nx);
      end
    end
  end

  assign act_o        = act_q;
  assign done_o       = done_q;
  assign ext_o        = ext_q;
  assign rf_clr_o     = rf_clr_q;
  assign dbg_status_o = status_q;
  assign trap_sched_o = trap_q;
  assign pending_o    = pend_q;

  a_r1_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_q && !wake_ok) |=> !done_o);
  a_r1_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && wake_ok && trap_set_i == '0) |=> (done_o && act_o == ACT_WAKE && trap_sched_o == '0));
  a_r2_task_first: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && trap_q[TASK_BIT]) |=> (done_o && act_o == ACT_DBG));
  a_r3_dbg_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && !trap_q[TASK_BIT] && inh_q[1]) |=> (act_o != ACT_DBG));
  a_r4_int_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && act_o == ACT_INT) |-> $past(intr_i && if_i && !inh_q[0]));
  a_r5_hold_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && act_o == ACT_HOLD) |-> $past(hold_req_i));
  a_r8_inh_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && !inh_int_set_i && !inh_dbg_set_i) |=> (inh_q == 2'b00));
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    normal |=> (done_o && act_o <= ACT_HOLD));
endmodule

// File: tb/boundary_event_arbiter_bench.sv
module boundary_event_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_i = 0, halt_i = 0, wake_rst_i = 0, tf_i = 0, rf_i = 0, if_i = 0;
  logic intr_i = 0, hold_req_i = 0, inh_int_set_i = 0, inh_dbg_set_i = 0;
  logic [31:0] trap_set_i = '0;
  logic [2:0]  act_o;
  logic        done_o, ext_o, rf_clr_o, pending_o;
  logic [31:0] dbg_status_o, trap_sched_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  boundary_event_arbiter u_boundary_event_arbiter (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .halt_i(halt_i), .wake_rst_i(wake_rst_i),
    .trap_set_i(trap_set_i), .tf_i(tf_i), .rf_i(rf_i), .if_i(if_i), .intr_i(intr_i),
    .hold_req_i(hold_req_i), .inh_int_set_i(inh_int_set_i), .inh_dbg_set_i(inh_dbg_set_i),
    .act_o(act_o), .done_o(done_o), .ext_o(ext_o), .rf_clr_o(rf_clr_o),
    .dbg_status_o(dbg_status_o), .trap_sched_o(trap_sched_o), .pending_o(pending_o));

  // {pre_trap[15:0], inh_int, inh_dbg, tf, rf, if, intr, hold, act[2:0], rf_clr, sched[15:0]}
  localparam int NV = 14;
  localparam logic [42:0] VEC [NV] = '{
    {16'h0000, 7'b0000000, 3'd0, 1'b0, 16'h0000}, // R10 continue
    {16'h0000, 7'b0000110, 3'd3, 1'b0, 16'h0000}, // R4 interrupt
    {16'h0000, 7'b0000011, 3'd4, 1'b0, 16'h0000}, // R5 IF clear -> hold
    {16'h0000, 7'b0000111, 3'd3, 1'b0, 16'h0000}, // R5 interrupt beats hold
    {16'h0000, 7'b1000111, 3'd4, 1'b0, 16'h0000}, // R8 int inhibited -> hold
    {16'h0001, 7'b0000000, 3'd2, 1'b0, 16'h0000}, // R3 trap taken
    {16'h0001, 7'b0100110, 3'd3, 1'b0, 16'h0001}, // R3 trap deferred
    {16'h0000, 7'b0000000, 3'd2, 1'b0, 16'h0000}, // R3 deferred trap fires
    {16'h8000, 7'b0100000, 3'd2, 1'b0, 16'h0000}, // R2 task bit ignores inhibit
    {16'h0000, 7'b0011000, 3'd0, 1'b1, 16'h4000}, // R6 R7 step scheduled, RF cleared
    {16'h0000, 7'b0001000, 3'd2, 1'b0, 16'h0000}, // R6 step fires, R7 no clear
    {16'h0000, 7'b0010110, 3'd3, 1'b0, 16'h4000}, // R6 step with interrupt
    {16'h0000, 7'b0100000, 3'd0, 1'b0, 16'h4000}, // R3 step deferred
    {16'h0000, 7'b0000000, 3'd2, 1'b0, 16'h0000}  // R11 step fires
  };
  string tags [NV] = '{"R10","R4","R5","R5","R8","R3","R3","R3","R2","R6","R6","R6","R3","R11"};

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset done", {31'b0, done_o}, 32'd0);
    chk("R11 reset status", dbg_status_o, 32'd0);
    chk("R9 reset pending", {31'b0, pending_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [42:0] v;
      v = VEC[k];
      trap_set_i = {16'h0, v[42:27]};
      inh_int_set_i = v[26]; inh_dbg_set_i = v[25];
      @(negedge clk);
      trap_set_i = '0; inh_int_set_i = 0; inh_dbg_set_i = 0;
      tf_i = v[24]; rf_i = v[23]; if_i = v[22]; intr_i = v[21]; hold_req_i = v[20];
      eval_i = 1;
      @(negedge clk);
      eval_i = 0; tf_i = 0; rf_i = 0; if_i = 0; intr_i = 0; hold_req_i = 0;
      chk({tags[k], " done"}, {31'b0, done_o}, 32'd1);
      chk({tags[k], " act"}, {29'b0, act_o}, {29'b0, v[19:17]});
      chk({tags[k], " R7 rf_clr"}, {31'b0, rf_clr_o}, {31'b0, v[16]});
      chk({tags[k], " sched"}, trap_sched_o, {16'h0, v[15:0]});
      chk({tags[k], " R4 ext"}, {31'b0, ext_o}, {31'b0, v[19:17] == 3'd3});
      @(negedge clk);
      chk("R10 single strobe", {31'b0, done_o}, 32'd0);
    end
    chk("R11 status accumulated", dbg_status_o, 32'h0000C001);
    chk("R9 pending cleared", {31'b0, pending_o}, 32'd0);

    // R9 pending flag follows a held request
    hold_req_i = 1;
    @(negedge clk);
    chk("R9 pending set", {31'b0, pending_o}, 32'd1);
    eval_i = 1;
    @(negedge clk);
    eval_i = 0;
    chk("R5 hold ack", {29'b0, act_o}, 32'd4);
    chk("R9 pending stays", {31'b0, pending_o}, 32'd1);
    hold_req_i = 0;
    @(negedge clk);
    eval_i = 1;
    @(negedge clk);
    eval_i = 0;
    chk("R9 pending drops", {31'b0, pending_o}, 32'd0);

    // R1 halt with stale trap and interrupt inhibit
    trap_set_i = 32'h0000_0002; inh_int_set_i = 1;
    @(negedge clk);
    trap_set_i = '0; inh_int_set_i = 0;
    halt_i = 1; eval_i = 1;
    @(negedge clk);
    eval_i = 0; halt_i = 0;
    for (int w = 0; w < 3; w++) begin
      chk("R1 halted idle", {31'b0, done_o}, 32'd0);
      @(negedge clk);
    end
    intr_i = 1; if_i = 1;
    @(negedge clk);
    intr_i = 0; if_i = 0;
    chk("R1 wake done", {31'b0, done_o}, 32'd1);
    chk("R1 wake act", {29'b0, act_o}, 32'd1);
    chk("R1 traps cleared", trap_sched_o, 32'd0);
    intr_i = 1; if_i = 1; eval_i = 1;
    @(negedge clk);
    eval_i = 0; intr_i = 0; if_i = 0;
    chk("R1 inhibit cleared -> int", {29'b0, act_o}, 32'd3);

    // R1 reset-event wake
    halt_i = 1; eval_i = 1;
    @(negedge clk);
    halt_i = 0; eval_i = 0;
    chk("R1 idle before reset event", {31'b0, done_o}, 32'd0);
    wake_rst_i = 1;
    @(negedge clk);
    wake_rst_i = 0;
    chk("R1 reset-event wake", {29'b0, act_o}, 32'd1);
    chk("R11 status sticky", dbg_status_o, 32'h0000C001);
    finish_up();
  end
endmodule